// File: doc/BRIEF.md
# Power management event signal controller

This block generates the active-low power management event pin of a network controller. Three detectors report wake events to it as single-cycle pulses: reception of a magic packet, a link state change, and a matching wakeup frame. Any of these pulses sets a sticky event status bit. Host software clears that bit by writing a one to bit 15 of the power management control/status word.

The pin is driven low only when three things are true: the status bit is set, the device-level wake enable is set, and the configuration-space wake enable is set. A strap input can also forbid wake signalling from the fully-on state. When ACPI mode is active, the strap is cleared and the power state is D0, the pin is held high. The status bit keeps recording events while the pin is held high.

The pin is a combinational function of the registered status and the live enable and state inputs. A change of power state therefore takes effect with no added delay.

Top module: `pme_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until an event arrives, the status output is 0 and `pme_n` is 1.
- R2: A pulse on any one of `magic_evt`, `link_evt` or `frame_evt` sets `pme_status` to 1 from the next clock edge.
- R3: Once set, `pme_status` stays 1 in every following cycle that has no clearing write.
- R4: A cycle with `stat_wr`=1 and `stat_wdata[15]`=1 clears `pme_status` at the next edge. A write with bit 15 = 0 leaves the status unchanged, whatever the other data bits are.
- R5: If an event pulse and a clearing write fall in the same cycle, `pme_status` is 1 after that edge.
- R6: `pme_n` is 0 exactly when `pme_status`, `dev_pm_en` and `cfg_pme_en` are all 1 and the D0 block of R7 does not apply. The pin responds to the enables in the same cycle.
- R7: When `acpi_mode`=1, `d0_wake_ok`=0 and `pwr_state`=0 (D0; the encoding is 0=D0, 1=D1, 2=D2, 3=D3), `pme_n` is 1. Setting the strap, leaving ACPI mode, or being in any of D1 to D3 lifts this block.
- R8: A change of `pwr_state` changes `pme_n` in the same cycle, with no delay cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| magic_evt | input | 1 | Magic packet received pulse |
| link_evt | input | 1 | Link change pulse |
| frame_evt | input | 1 | Wakeup frame match pulse |
| dev_pm_en | input | 1 | Device-level wake enable |
| cfg_pme_en | input | 1 | Configuration-space wake enable |
| pwr_state | input | 2 | Current power state, 0=D0 to 3=D3 |
| acpi_mode | input | 1 | ACPI mode active |
| d0_wake_ok | input | 1 | Strap: wake signalling permitted from D0 |
| stat_wr | input | 1 | Status word write strobe |
| stat_wdata | input | 16 | Status word write data, bit 15 clears status |
| pme_status | output | 1 | Sticky event status |
| pme_n | output | 1 | Active-low power management event pin |

## Verification
The assertions assume that event pulses and writes are synchronous to `clk` and held stable across each rising edge. They also assume that nothing arrives while the internal reset is still being released; the checker is disabled using that internal reset. The stimulus changes every input 2 ns after a rising edge and waits several cycles after reset before the first event. A behavioural model compares status and pin on every falling edge. Directed phases cover each event source alone, writes with and without bit 15, a clash between a set and a clear, toggling of both enables, every combination of strap and ACPI mode in D0, and a power state that changes every cycle.

// File: rtl/pme_pkg.sv
package pme_pkg;
  localparam int PSTATE_W = 2;
  localparam int NUM_EVT  = 3;

  typedef enum logic [PSTATE_W-1:0] {
    PS_D0 = 2'd0,
    PS_D1 = 2'd1,
    PS_D2 = 2'd2,
    PS_D3 = 2'd3
  } pstate_e;
endpackage

// File: rtl/pme_rst_sync.sv
module pme_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/pme_status_reg.sv
module pme_status_reg #(
  parameter int NUM_EVT = 3,
  parameter int DATA_W  = 16,
  parameter int CLR_BIT = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               wr,
  input  logic [DATA_W-1:0]  wdata,
  output logic               status
);
  logic any_evt;
  logic clr_req;
  logic stat_en;
  logic stat_d;

  always_comb begin
    any_evt = |evt;
    clr_req = wr & wdata[CLR_BIT];
    stat_en = any_evt | clr_req;
    stat_d  = any_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status <= 1'b0;
    else if (stat_en) status <= stat_d;
  end
endmodule

// File: rtl/pme_gate.sv
module pme_gate
  import pme_pkg::*;
(
  input  logic    status,
  input  logic    dev_en,
  input  logic    cfg_en,
  input  logic    acpi_mode,
  input  logic    d0_wake_ok,
  input  pstate_e pstate,
  output logic    pin_n
);
  logic d0_block;
  logic fire;

  always_comb begin
    d0_block = acpi_mode & ~d0_wake_ok & (pstate == PS_D0);
    fire     = status & dev_en & cfg_en & ~d0_block;
    pin_n    = ~fire;
  end
endmodule

// File: rtl/pme_ctrl.sv
module pme_ctrl
  import pme_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CLR_BIT     = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                magic_evt,
  input  logic                link_evt,
  input  logic                frame_evt,
  input  logic                dev_pm_en,
  input  logic                cfg_pme_en,
  input  logic [PSTATE_W-1:0] pwr_state,
  input  logic                acpi_mode,
  input  logic                d0_wake_ok,
  input  logic                stat_wr,
  input  logic [DATA_W-1:0]   stat_wdata,
  output logic                pme_status,
  output logic                pme_n
);
  logic               rst_q_n;
  logic [NUM_EVT-1:0] evt_vec;
  pstate_e            pstate;

  assign evt_vec = {frame_evt, link_evt, magic_evt};
  assign pstate  = pstate_e'(pwr_state);

  pme_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  pme_status_reg #(
    .NUM_EVT (NUM_EVT),
    .DATA_W  (DATA_W),
    .CLR_BIT (CLR_BIT)
  ) u_stat (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .evt    (evt_vec),
    .wr     (stat_wr),
    .wdata  (stat_wdata),
    .status (pme_status)
  );

  pme_gate u_gate (
    .status     (pme_status),
    .dev_en     (dev_pm_en),
    .cfg_en     (cfg_pme_en),
    .acpi_mode  (acpi_mode),
    .d0_wake_ok (d0_wake_ok),
    .pstate     (pstate),
    .pin_n      (pme_n)
  );
endmodule

// File: rtl/pme_ctrl_chk.sv
module pme_ctrl_chk #(
  parameter int DATA_W  = 16,
  parameter int CLR_BIT = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              magic_evt,
  input logic              link_evt,
  input logic              frame_evt,
  input logic              dev_pm_en,
  input logic              cfg_pme_en,
  input logic [1:0]        pwr_state,
  input logic              acpi_mode,
  input logic              d0_wake_ok,
  input logic              stat_wr,
  input logic [DATA_W-1:0] stat_wdata,
  input logic              pme_status,
  input logic              pme_n
);
  logic evt_any;
  logic clr_wr;
  logic blk;
  assign evt_any = magic_evt | link_evt | frame_evt;
  assign clr_wr  = stat_wr & stat_wdata[CLR_BIT];
  assign blk     = acpi_mode & ~d0_wake_ok & (pwr_state == 2'd0);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!pme_status && pme_n)); // R1
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n) evt_any |=> pme_status); // R2
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (pme_status && !clr_wr) |=> pme_status); // R3
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (clr_wr && !evt_any) |=> !pme_status); // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n) (!pme_status && !evt_any) |=> !pme_status); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (evt_any && clr_wr) |=> pme_status); // R5
  AST_PIN_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n) !pme_n |-> (pme_status && dev_pm_en && cfg_pme_en)); // R6
  AST_PIN_FIRES: assert property (@(posedge clk) disable iff (!rst_n) (pme_status && dev_pm_en && cfg_pme_en && !blk) |-> !pme_n); // R6
  AST_D0_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) blk |-> pme_n); // R7
endmodule

bind pme_ctrl pme_ctrl_chk #(.DATA_W(DATA_W), .CLR_BIT(CLR_BIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .magic_evt  (magic_evt),
  .link_evt   (link_evt),
  .frame_evt  (frame_evt),
  .dev_pm_en  (dev_pm_en),
  .cfg_pme_en (cfg_pme_en),
  .pwr_state  (pwr_state),
  .acpi_mode  (acpi_mode),
  .d0_wake_ok (d0_wake_ok),
  .stat_wr    (stat_wr),
  .stat_wdata (stat_wdata),
  .pme_status (pme_status),
  .pme_n      (pme_n)
);

// File: tb/test_pme_ctrl.sv
`timescale 1ns/1ps
module test_pme_ctrl;
  logic        clk;
  logic        rst_n;
  logic        magic_evt, link_evt, frame_evt;
  logic        dev_pm_en, cfg_pme_en;
  logic [1:0]  pwr_state;
  logic        acpi_mode, d0_wake_ok;
  logic        stat_wr;
  logic [15:0] stat_wdata;
  logic        pme_status, pme_n;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit settled  = 0;
  bit m_stat   = 0;
  string tag   = "R1";

  pme_ctrl i_pme_ctrl (
    .clk(clk), .rst_n(rst_n), .magic_evt(magic_evt), .link_evt(link_evt),
    .frame_evt(frame_evt), .dev_pm_en(dev_pm_en), .cfg_pme_en(cfg_pme_en),
    .pwr_state(pwr_state), .acpi_mode(acpi_mode), .d0_wake_ok(d0_wake_ok),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .pme_status(pme_status),
    .pme_n(pme_n)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(string t, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", t, what, act, exp, $time);
    end
  endtask

  function automatic bit model_pin();
    bit blk;
    blk = acpi_mode && !d0_wake_ok && (pwr_state == 2'd0);
    return !(m_stat && dev_pm_en && cfg_pme_en && !blk);
  endfunction

  // reference model: sticky bit, set beats clear
  always @(posedge clk) begin
    cycles++;
    if (!settled) m_stat = 0;
    else if (magic_evt || link_evt || frame_evt) m_stat = 1;
    else if (stat_wr && stat_wdata[15]) m_stat = 0;
  end

  always @(negedge clk) begin
    if (settled) begin
      check(tag, "pme_status", pme_status, m_stat);
      check(tag, "pme_n", pme_n, model_pin());
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic idle();
    magic_evt = 0; link_evt = 0; frame_evt = 0; stat_wr = 0; stat_wdata = '0;
  endtask

  task automatic pulse(int which);
    step();
    magic_evt = (which == 0); link_evt = (which == 1); frame_evt = (which == 2);
    step(); idle();
  endtask

  task automatic wr(logic [15:0] d);
    step(); stat_wr = 1; stat_wdata = d;
    step(); idle();
  endtask

  initial begin
    #160000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; idle();
    dev_pm_en = 1; cfg_pme_en = 1; pwr_state = 2'd3; acpi_mode = 0; d0_wake_ok = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", "pme_status in reset", pme_status, 1'b0);
    check("R1", "pme_n in reset", pme_n, 1'b1);
    rst_n = 1;
    step(4);
    settled = 1;
    tag = "R1"; step(3);
    check("R1", "pme_n after reset", pme_n, 1'b1);

    tag = "R2";
    for (int k = 0; k < 3; k++) begin
      pulse(k); step(2);
      check("R2", "status after event", pme_status, 1'b1);
      wr(16'h8000); step();
    end

    tag = "R3"; pulse(1); step(8);
    check("R3", "status sticky", pme_status, 1'b1);

    tag = "R4";
    wr(16'h0000); step();
    wr(16'h7FFF); step();
    check("R4", "write without bit15", pme_status, 1'b1);
    wr(16'h8000); step();
    check("R4", "write bit15 clears", pme_status, 1'b0);
    check("R4", "pin released", pme_n, 1'b1);
    wr(16'hFFFF); step();

    tag = "R5";
    step(); frame_evt = 1; stat_wr = 1; stat_wdata = 16'h8000;
    step(); idle(); step();
    check("R5", "set wins over clear", pme_status, 1'b1);
    pulse(0); step(); step(); stat_wr = 1; stat_wdata = 16'h8000; magic_evt = 1;
    step(); idle(); step();

    tag = "R6";
    for (int k = 0; k < 4; k++) begin
      step(); dev_pm_en = k[0]; cfg_pme_en = k[1];
      #1 check("R6", "pin vs enables", pme_n, !(k == 3));
      step();
    end
    wr(16'h8000); step(2);

    tag = "R7"; pulse(2); step();
    for (int k = 0; k < 8; k++) begin
      step(); acpi_mode = k[0]; d0_wake_ok = k[1]; pwr_state = k[2] ? 2'd2 : 2'd0;
      #1 check("R7", "D0 block", pme_n, (k == 1));
      step();
    end

    tag = "R8"; acpi_mode = 1; d0_wake_ok = 0;
    for (int k = 0; k < 12; k++) begin
      step(); pwr_state = 2'(k % 4);
      #1 check("R8", "pin follows state", pme_n, (k % 4) == 0);
    end
    pwr_state = 2'd1; step(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule